// File: doc/BRIEF.md
# Multi-Mode Operand Fetch Unit

This unit resolves one instruction operand from an addressing-mode code and returns the operand's value. Its inputs for each request are the mode code, two register-file read values, a 16-bit immediate or offset field, and a 32-bit absolute address field. From these it forms an effective address. It then makes zero, one or two reads on a simple synchronous memory port, depending on the mode.

Requests are accepted only when the unit is idle. Modes that need no memory finish in the cycle after acceptance. Memory modes hold a read request until the memory answers, and there is no limit on how long the memory may take.

In the memory-indirect mode the second read depends on the first. The first read fetches a pointer from the absolute address, and the data it returns becomes the address of the second read. The result is held on the outputs with a one-cycle completion strobe until the next request completes.

Top module: `opnd_fetch`

## Requirements
- R1: After a synchronous active-high reset, `done`, `err`, `busy` and `mem_req` are low, and `operand` and `ea_out` are zero.
- R2: Mode code 0 (immediate) returns the sign-extended 16-bit `imm` as the operand with `ea_out` zero. It makes no memory read, and `done` is high in the cycle after acceptance.
- R3: Mode code 1 (register) returns `reg_a` as the operand with `ea_out` zero. It makes no memory read, and `done` is high in the cycle after acceptance.
- R4: Mode code 2 (direct) reads memory once at `abs_addr`, reports `abs_addr` as `ea_out`, and returns the read data as the operand.
- R5: Mode code 3 (register indirect) reads memory once at `reg_a` and reports that address as `ea_out`.
- R6: Mode code 4 (indexed) reads memory once at `reg_a` plus the sign-extended `imm`, so negative offsets subtract.
- R7: Mode code 5 (base plus index) reads memory once at `reg_a + reg_b` plus the sign-extended `imm`.
- R8: Mode code 6 (memory indirect) reads memory twice. The first read is at `abs_addr`. The second read is at the data the first read returned. `ea_out` is that returned pointer, and the operand is the data from the second read.
- R9: Mode code 7 is undefined. It completes in the cycle after acceptance with `operand` and `ea_out` zero, and `err` is high for that one cycle only.
- R10: A `start` seen while `busy` is high is ignored. The operation in flight finishes with its own result, and no extra `done` follows.
- R11: While `mem_req` is high and `mem_valid` is low, `mem_req` stays high and `mem_addr` stays unchanged, for any number of wait cycles.
- R12: `done` is high for exactly one cycle per accepted request. `operand` and `ea_out` keep their values until the next request completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe; accepted only while idle |
| mode | input | 3 | Addressing-mode code |
| reg_a | input | 32 | First register value (base or pointer) |
| reg_b | input | 32 | Second register value (index) |
| imm | input | 16 | Immediate value or signed offset |
| abs_addr | input | 32 | Absolute address field |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_valid | input | 1 | Read data valid; completes the pending read |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | A memory operation is in progress |
| done | output | 1 | One-cycle completion strobe |
| operand | output | 32 | Resolved operand value |
| ea_out | output | 32 | Effective address of the operand |
| err | output | 1 | Undefined mode, high together with `done` |

## Verification
The bench builds the unit with its default parameters: 32-bit addresses and data, and a 16-bit offset. With these, a full-width carry in the base-plus-index sum, wrap-around from negative offsets, and sign extension across bit 15 can all be reached. A memory model in the bench returns a scrambled function of the address, so a pointer and the operand it leads to always differ. The model's wait count, set per vector up to 20 cycles, covers both back-to-back answers and long stalls during the chained indirect read.

// File: rtl/opf_pkg.sv
package opf_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    AM_IMM    = 3'd0,
    AM_REG    = 3'd1,
    AM_DIRECT = 3'd2,
    AM_RIND   = 3'd3,
    AM_INDEX  = 3'd4,
    AM_BIDX   = 3'd5,
    AM_MIND   = 3'd6,
    AM_BAD    = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RD1  = 2'd1,
    SQ_RD2  = 2'd2
  } sq_state_e;
endpackage

// File: rtl/opf_ea_gen.sv
module opf_ea_gen #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic [2:0]        mode,
  input  logic [DATA_W-1:0] reg_a,
  input  logic [DATA_W-1:0] reg_b,
  input  logic [OFF_W-1:0]  imm,
  input  logic [ADDR_W-1:0] abs_addr,
  output logic [ADDR_W-1:0] first_addr,
  output logic [DATA_W-1:0] direct_val,
  output logic              needs_mem,
  output logic              two_reads,
  output logic              bad_mode
);
  import opf_pkg::*;

  logic [ADDR_W-1:0] off_ext;
  logic [DATA_W-1:0] imm_ext;

  generate
    if (OFF_W < ADDR_W) begin : g_off_sx
      assign off_ext = {{(ADDR_W-OFF_W){imm[OFF_W-1]}}, imm};
    end else begin : g_off_tr
      assign off_ext = imm[ADDR_W-1:0];
    end
    if (OFF_W < DATA_W) begin : g_imm_sx
      assign imm_ext = {{(DATA_W-OFF_W){imm[OFF_W-1]}}, imm};
    end else begin : g_imm_tr
      assign imm_ext = imm[DATA_W-1:0];
    end
  endgenerate

  logic [ADDR_W-1:0] ra_a, rb_a;
  assign ra_a = ADDR_W'(reg_a);
  assign rb_a = ADDR_W'(reg_b);

  always_comb begin
    first_addr = '0;
    direct_val = '0;
    needs_mem  = 1'b0;
    two_reads  = 1'b0;
    bad_mode   = 1'b0;
    case (amode_e'(mode))
      AM_IMM:    direct_val = imm_ext;
      AM_REG:    direct_val = reg_a;
      AM_DIRECT: begin first_addr = abs_addr;              needs_mem = 1'b1; end
      AM_RIND:   begin first_addr = ra_a;                  needs_mem = 1'b1; end
      AM_INDEX:  begin first_addr = ra_a + off_ext;        needs_mem = 1'b1; end
      AM_BIDX:   begin first_addr = ra_a + rb_a + off_ext; needs_mem = 1'b1; end
      AM_MIND:   begin first_addr = abs_addr; needs_mem = 1'b1; two_reads = 1'b1; end
      default:   bad_mode = 1'b1;
    endcase
  end
endmodule

// File: rtl/opf_seq.sv
module opf_seq #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic              two_reads,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              busy,
  output logic              fin
);
  import opf_pkg::*;

  sq_state_e st;
  logic      chain;
  logic      hit;

  assign hit  = mem_req && mem_valid;
  assign busy = (st != SQ_IDLE);
  assign fin  = hit && ((st == SQ_RD2) || (st == SQ_RD1 && !chain));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      chain    <= 1'b0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (launch) begin
          st       <= SQ_RD1;
          chain    <= two_reads;
          mem_req  <= 1'b1;
          mem_addr <= first_addr;
        end
        SQ_RD1: if (hit) begin
          if (chain) begin
            st       <= SQ_RD2;
            mem_addr <= ADDR_W'(mem_rdata);
          end else begin
            st      <= SQ_IDLE;
            mem_req <= 1'b0;
          end
        end
        SQ_RD2: if (hit) begin
          st      <= SQ_IDLE;
          mem_req <= 1'b0;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/opnd_fetch.sv
module opnd_fetch #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [DATA_W-1:0] reg_a,
  input  logic [DATA_W-1:0] reg_b,
  input  logic [OFF_W-1:0]  imm,
  input  logic [ADDR_W-1:0] abs_addr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] operand,
  output logic [ADDR_W-1:0] ea_out,
  output logic              err
);
  logic [ADDR_W-1:0] first_addr;
  logic [DATA_W-1:0] direct_val;
  logic needs_mem, two_reads, bad_mode;
  logic accept, launch, fin;

  assign accept = start && !busy;
  assign launch = accept && needs_mem;

  opf_ea_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_ea (
    .mode       (mode),
    .reg_a      (reg_a),
    .reg_b      (reg_b),
    .imm        (imm),
    .abs_addr   (abs_addr),
    .first_addr (first_addr),
    .direct_val (direct_val),
    .needs_mem  (needs_mem),
    .two_reads  (two_reads),
    .bad_mode   (bad_mode)
  );

  opf_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .launch     (launch),
    .first_addr (first_addr),
    .two_reads  (two_reads),
    .mem_valid  (mem_valid),
    .mem_rdata  (mem_rdata),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .busy       (busy),
    .fin        (fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      err     <= 1'b0;
      operand <= '0;
      ea_out  <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (accept && !needs_mem) begin
        done    <= 1'b1;
        err     <= bad_mode;
        operand <= direct_val;
        ea_out  <= '0;
      end else if (fin) begin
        done    <= 1'b1;
        operand <= mem_rdata;
        ea_out  <= mem_addr;
      end
    end
  end
endmodule

// File: rtl/opf_checker.sv
module opf_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [2:0]        mode,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [DATA_W-1:0] operand,
  input logic [ADDR_W-1:0] ea_out,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_valid
);
  // R11: pending read holds request and address
  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // R9: error strobe only with done and zero results
  p_err_zero_r9: assert property (@(posedge clk) disable iff (rst)
    err |-> (done && operand == '0 && ea_out == '0));

  // R2, R3, R9: non-memory modes finish next cycle without a read
  p_fast_done_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (mode == 3'd0 || mode == 3'd1 || mode == 3'd7))
      |=> (done && !mem_req));

  // R10: no request issued while idle
  p_idle_noreq_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  // R12: done never while a read is still pending
  p_done_idle_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind opnd_fetch opf_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .mode      (mode),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .operand   (operand),
  .ea_out    (ea_out),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_valid (mem_valid)
);

// File: tb/tb_opnd_fetch.sv
module tb_opnd_fetch;
  typedef struct packed {
    logic [2:0]  md;
    logic [31:0] ra;
    logic [31:0] rb;
    logic [15:0] im;
    logic [31:0] ab;
    logic [7:0]  wt;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'h1111_2222, 32'h0, 16'h7FFF, 32'h0, 8'd0},             // R2 positive
    '{3'd0, 32'h0, 32'h0, 16'h8001, 32'hDEAD_0000, 8'd0},             // R2 negative
    '{3'd1, 32'hCAFE_F00D, 32'h1, 16'h1234, 32'h0, 8'd0},             // R3
    '{3'd2, 32'h0, 32'h0, 16'h0, 32'h8000_0040, 8'd0},                // R4
    '{3'd3, 32'h0000_1000, 32'h9, 16'h0, 32'h0, 8'd3},                // R5
    '{3'd4, 32'h0000_2000, 32'h0, 16'h0008, 32'h0, 8'd1},             // R6 positive
    '{3'd4, 32'h0000_2000, 32'h0, 16'hFFF0, 32'h0, 8'd2},             // R6 negative
    '{3'd5, 32'hFFFF_FFF0, 32'h0000_0020, 16'hFFFC, 32'h0, 8'd0},     // R7 carry
    '{3'd6, 32'h0, 32'h0, 16'h0, 32'h0000_3000, 8'd0},                // R8
    '{3'd6, 32'h5, 32'h6, 16'h7, 32'h1234_5678, 8'd20},               // R8 long wait
    '{3'd7, 32'h7777_7777, 32'h1, 16'h1, 32'h1, 8'd0}                 // R9
  };

  logic clk = 0;
  logic rst = 1;
  logic start = 0;
  logic [2:0] mode = 0;
  logic [31:0] reg_a = 0, reg_b = 0, abs_addr = 0;
  logic [15:0] imm = 0;
  logic mem_valid = 0;
  logic [31:0] mem_rdata = 0;
  logic mem_req, busy, done, err;
  logic [31:0] mem_addr, operand, ea_out;

  int n_chk = 0, n_bad = 0, nreads = 0, wait_cfg = 0, wcnt = 0;

  always #5 clk = ~clk;

  opnd_fetch dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .reg_a(reg_a),
    .reg_b(reg_b), .imm(imm), .abs_addr(abs_addr), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .operand(operand), .ea_out(ea_out), .err(err)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A5A_1234;
  endfunction

  // memory model: answers after wait_cfg idle cycles, valid lasts one cycle
  always @(negedge clk) begin
    if (mem_valid) begin
      mem_valid <= 1'b0;
      wcnt <= 0;
    end else if (mem_req) begin
      if (wcnt >= wait_cfg) begin
        mem_valid <= 1'b1;
        mem_rdata <= memf(mem_addr);
        nreads <= nreads + 1;
        wcnt <= 0;
      end else wcnt <= wcnt + 1;
    end else wcnt <= 0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_of(input vec_t v, output logic [31:0] e_op, output logic [31:0] e_ea,
                           output int e_rd, output logic e_err);
    logic [31:0] sx = {{16{v.im[15]}}, v.im};
    e_err = 0; e_rd = 1; e_ea = 0; e_op = 0;
    case (v.md)
      3'd0: begin e_op = sx; e_rd = 0; end
      3'd1: begin e_op = v.ra; e_rd = 0; end
      3'd2: e_ea = v.ab;
      3'd3: e_ea = v.ra;
      3'd4: e_ea = v.ra + sx;
      3'd5: e_ea = v.ra + v.rb + sx;
      3'd6: begin e_ea = memf(v.ab); e_rd = 2; end
      default: begin e_rd = 0; e_err = 1; end
    endcase
    if (v.md >= 3'd2 && v.md <= 3'd6) e_op = memf(e_ea);
  endtask

  task automatic run(input vec_t v, input string tag, input bit poke_busy);
    logic [31:0] e_op, e_ea; int e_rd; logic e_err; int cyc;
    expect_of(v, e_op, e_ea, e_rd, e_err);
    @(negedge clk);
    nreads = 0; wait_cfg = int'(v.wt);
    mode = v.md; reg_a = v.ra; reg_b = v.rb; imm = v.im; abs_addr = v.ab;
    start = 1;
    @(negedge clk);
    start = 0;
    mode = 3'd0; imm = 16'h0BAD; reg_a = 32'hBAD0_BAD0; abs_addr = 32'hFFFF_0000;
    cyc = 1;
    if (poke_busy) begin
      start = 1;            // R10: must be ignored while busy
      @(negedge clk); start = 0; cyc++;
    end
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
    if (e_rd == 0) chk({tag, " latency"}, cyc, 1);
    chk({tag, " done"}, {31'd0, done}, 32'd1);
    chk({tag, " operand"}, operand, e_op);
    chk({tag, " ea"}, ea_out, e_ea);
    chk({tag, " err"}, {31'd0, err}, {31'd0, e_err});
    chk({tag, " reads"}, nreads, e_rd);
    @(negedge clk);
    chk("R12 done single cycle", {31'd0, done}, 32'd0);
    chk("R12 operand held", operand, e_op);
    chk("R9 err single cycle", {31'd0, err}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 done", {31'd0, done}, 0);
    chk("R1 mem_req", {31'd0, mem_req}, 0);
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 err", {31'd0, err}, 0);
    chk("R1 operand", operand, 0);
    chk("R1 ea", ea_out, 0);
    for (int i = 0; i < NV; i++) begin
      string t;
      case (VECS[i].md)
        3'd0: t = "R2"; 3'd1: t = "R3"; 3'd2: t = "R4"; 3'd3: t = "R5";
        3'd4: t = "R6"; 3'd5: t = "R7"; 3'd6: t = "R8"; default: t = "R9";
      endcase
      run(VECS[i], t, 1'b0);
    end
    // R10: start while busy during a chained indirect read
    run('{3'd6, 32'h0, 32'h0, 16'h0, 32'h0000_ABCD, 8'd5}, "R10", 1'b1);
    // R11: long stall on a single read; address checked at completion
    run('{3'd3, 32'h0040_0000, 32'h0, 16'h0, 32'h0, 8'd17}, "R11", 1'b0);
    // R12: back-to-back register mode after memory op
    run('{3'd1, 32'h0000_0001, 32'h0, 16'h0, 32'h0, 8'd0}, "R12", 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule